// File: doc/BRIEF.md
# Synchronous SRAM Write Access Controller

This block sits at the front of a pipelined synchronous SRAM with a shared data bus. On every rising clock edge it samples two competing address strobes, three chip enables of mixed polarity and a set of write controls: a global-write input, a byte-write enable and one select per byte lane. It decides whether a single-cycle write starts. When a write is decoded, the presented address is loaded into the address register, which also serves as the burst counter. The selected byte lanes of the write data are stored in a behavioural memory array at that same edge.

The block also produces the enable for the shared data bus drivers. During any cycle in which a write is decoded, that enable is forced low, whatever the output-enable input is doing. Outside writes, a burst-step input advances the two low address bits, wrapping modulo four. A combinational read port exposes the array contents so that the stored data can be observed. Every control pin is a plain per-cycle level. There is no valid/ready handshake and no back-pressure: the block accepts a decision on every clock and can never stall its source.

Top module: `sram_wr_ctrl`

## Requirements
- R1: A write is decoded only when `ctl_strobe_n` is 0, `cpu_strobe_n` is 1, all three chip enables are active and at least one lane strobe results; with `cpu_strobe_n` at 0 nothing is written.
- R2: Chip enables are decoded as `en_a_n` active low, `en_b` active high and `en_c_n` active low; if any one is inactive no byte of the array changes.
- R3: With `all_wr_n` at 0, every byte lane is stored, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R4: With `all_wr_n` at 1 and `lane_wr_en_n` at 0, lane i (bits 8i+7..8i of `wdata`) is stored exactly when `lane_sel_n[i]` is 0, and the other lanes keep their old contents.
- R5: With `all_wr_n` at 1 and `lane_wr_en_n` at 1, no write happens.
- R6: A write completes at the edge that samples it: from that edge on, `rd_data` at the written address shows the new bytes.
- R7: At a write edge `burst_addr` is loaded with `addr`, whatever the value of `step_n`.
- R8: At a non-write edge, `step_n` at 0 increments the two low bits of `burst_addr` modulo 4 and leaves the upper bits unchanged; `step_n` at 1 holds the value; reset clears it to 0.
- R9: `bus_drive_en` is 1 exactly when `oe_n` is 0 and no write is decoded from the current inputs; a decoded write forces it to 0 even with `oe_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane byte-write select, active low |
| step_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Write address |
| wdata | input | 8*LANES | Write data |
| rd_addr | input | AW | Read port address |
| rd_data | output | 8*LANES | Array contents at `rd_addr` |
| burst_addr | output | AW | Address register / burst counter |
| bus_drive_en | output | 1 | Data bus driver enable |

## Verification
The assertions assume that every control input holds a known 0 or 1 level at each sampling edge once reset is released, and that `addr` stays inside the array. The bench drives every input only at falling edges. It walks all 8192 combinations of the strobes, enables, write controls, lane selects, step and output enable, using in-range addresses. It first fills the whole array with global writes, so no read compares against uninitialised storage.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_DESEL = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  localparam int LANE_W = 8;
  localparam int STEP_W = 2;

  function automatic logic [STEP_W-1:0] wrap_step(input logic [STEP_W-1:0] v);
    return v + 1'b1;
  endfunction
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_strobe_n,
  input  logic             cpu_strobe_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_hit,
  output sram_wr_pkg::cyc_e cyc
);
  import sram_wr_pkg::*;

  logic             chips_on;
  logic             strobe_ok;
  logic [LANES-1:0] lane_mask;

  assign chips_on  = !en_a_n && en_b && !en_c_n;
  assign strobe_ok = !ctl_strobe_n && cpu_strobe_n;

  always_comb begin
    if (!all_wr_n)          lane_mask = '1;
    else if (!lane_wr_en_n) lane_mask = ~lane_sel_n;
    else                    lane_mask = '0;
  end

  assign wr_hit  = chips_on && strobe_ok && (|lane_mask);
  assign lane_we = wr_hit ? lane_mask : '0;

  always_comb begin
    if (!chips_on)   cyc = CYC_DESEL;
    else if (wr_hit) cyc = CYC_WRITE;
    else             cyc = CYC_IDLE;
  end

  // R2
  deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_n || !en_b || en_c_n) |-> (lane_we == '0));
  // R1
  cpu_strobe_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_strobe_n |-> (lane_we == '0));
  // R3
  global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_WRITE && !all_wr_n) |-> (&lane_we));
endmodule

// File: rtl/sram_wr_addr.sv
module sram_wr_addr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic          step_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] addr_q
);
  import sram_wr_pkg::*;

  localparam int HI_W = AW - STEP_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (wr_hit) addr_q <= addr;
    else if (!step_n)
      addr_q <= {addr_q[AW-1:STEP_W], wrap_step(addr_q[STEP_W-1:0])};
  end

  // R7
  load_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (addr_q == $past(addr)));
  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && step_n) |=> $stable(addr_q));
  // R8
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !step_n) |=> (addr_q[AW-1:STEP_W] == $past(addr_q[AW-1:STEP_W])));

  if (HI_W < 0) begin : g_bad_width
    initial $display("sram_wr_addr: AW must be at least %0d", STEP_W);
  end
endmodule

// File: rtl/sram_wr_array.sv
module sram_wr_array #(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input  logic                                 clk,
  input  logic [LANES-1:0]                     lane_we,
  input  logic [AW-1:0]                        waddr,
  input  logic [LANES*sram_wr_pkg::LANE_W-1:0] wdata,
  input  logic [AW-1:0]                        raddr,
  output logic [LANES*sram_wr_pkg::LANE_W-1:0] rdata
);
  import sram_wr_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl #(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_strobe_n,
  input  logic                   cpu_strobe_n,
  input  logic                   en_a_n,
  input  logic                   en_b,
  input  logic                   en_c_n,
  input  logic                   all_wr_n,
  input  logic                   lane_wr_en_n,
  input  logic [LANES-1:0]       lane_sel_n,
  input  logic                   step_n,
  input  logic                   oe_n,
  input  logic [AW-1:0]          addr,
  input  logic [LANES*8-1:0]     wdata,
  input  logic [AW-1:0]          rd_addr,
  output logic [LANES*8-1:0]     rd_data,
  output logic [AW-1:0]          burst_addr,
  output logic                   bus_drive_en
);
  import sram_wr_pkg::*;

  logic [LANES-1:0] lane_we;
  logic             wr_hit;
  cyc_e             cyc;

  sram_wr_decode #(.LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .ctl_strobe_n(ctl_strobe_n), .cpu_strobe_n(cpu_strobe_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .lane_we(lane_we), .wr_hit(wr_hit), .cyc(cyc)
  );

  sram_wr_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .step_n(step_n),
    .addr(addr), .addr_q(burst_addr)
  );

  sram_wr_array #(.AW(AW), .LANES(LANES)) u_array (
    .clk(clk), .lane_we(lane_we), .waddr(addr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign bus_drive_en = !oe_n && (cyc != CYC_WRITE);

  // R9
  write_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> !bus_drive_en);
  // R9
  drive_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && lane_we == '0) |-> bus_drive_en);
endmodule

// File: tb/sram_wr_ctrl_test.sv
`timescale 1ns/1ps
module sram_wr_ctrl_test;
  localparam int AW = 4;
  localparam int LANES = 4;
  localparam int DW = LANES * 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_strobe_n = 1'b1, cpu_strobe_n = 1'b1;
  logic en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
  logic all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic step_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] burst_addr;
  logic bus_drive_en;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] exp_burst;

  always #2.5 clk = ~clk;

  sram_wr_ctrl #(.AW(AW), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_strobe_n(ctl_strobe_n), .cpu_strobe_n(cpu_strobe_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .step_n(step_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .burst_addr(burst_addr), .bus_drive_en(bus_drive_en)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    // reset state: R8 counter cleared, R9 drive with oe active and no write
    #12;
    check(burst_addr == '0, "R8 reset", DW'(burst_addr), '0);
    check(bus_drive_en == 1'b1, "R9 reset", DW'(bus_drive_en), 1);
    @(negedge clk);
    rst_n = 1'b1;
    exp_burst = '0;

    // prefill with global writes (R3, R6)
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ctl_strobe_n = 0; cpu_strobe_n = 1; en_a_n = 0; en_b = 1; en_c_n = 0;
      all_wr_n = 0; lane_wr_en_n = 1; lane_sel_n = '1; step_n = 0;
      addr = AW'(a); rd_addr = AW'(a);
      wdata = DW'(a) * 32'h01030507 + 32'h5a5a0000;
      ref_mem[a] = wdata;
      exp_burst = AW'(a);
      @(posedge clk); #1;
      check(rd_data == ref_mem[a], "R3 prefill", rd_data, ref_mem[a]);
      check(burst_addr == exp_burst, "R7 prefill", DW'(burst_addr), DW'(exp_burst));
    end

    // exhaustive sweep over control inputs
    for (int v = 0; v < 8192; v++) begin
      logic [LANES-1:0] m;
      logic chips, strobes, wr;
      int a;
      @(negedge clk);
      lane_sel_n   = v[3:0];
      lane_wr_en_n = v[4];
      all_wr_n     = v[5];
      en_c_n       = v[6];
      en_b         = v[7];
      en_a_n       = v[8];
      cpu_strobe_n = v[9];
      ctl_strobe_n = v[10];
      step_n       = v[11];
      oe_n         = v[12];
      a = (v * 7 + 3) % DEPTH;
      addr = AW'(a); rd_addr = AW'(a);
      wdata = DW'(v) * 32'h9e3779b9 + 32'h0badf00d;

      chips = !en_a_n && en_b && !en_c_n;
      strobes = !ctl_strobe_n && cpu_strobe_n;
      if (!all_wr_n) m = '1;
      else if (!lane_wr_en_n) m = ~lane_sel_n;
      else m = '0;
      wr = chips && strobes && (m != '0);
      #1;
      check(bus_drive_en == (!oe_n && !wr), wr ? "R9 write override" : "R9 drive",
            DW'(bus_drive_en), DW'(!oe_n && !wr));
      if (wr) begin
        for (int l = 0; l < LANES; l++)
          if (m[l]) ref_mem[a][l*8 +: 8] = wdata[l*8 +: 8];
        exp_burst = addr;
      end else if (!step_n) begin
        exp_burst = {exp_burst[AW-1:2], exp_burst[1:0] + 2'd1};
      end
      @(posedge clk); #1;
      if (!chips)
        check(rd_data == ref_mem[a], "R2 deselect", rd_data, ref_mem[a]);
      else if (!strobes)
        check(rd_data == ref_mem[a], "R1 strobe gating", rd_data, ref_mem[a]);
      else if (!all_wr_n)
        check(rd_data == ref_mem[a], "R3 global write", rd_data, ref_mem[a]);
      else if (!lane_wr_en_n)
        check(rd_data == ref_mem[a], "R4 byte write", rd_data, ref_mem[a]);
      else
        check(rd_data == ref_mem[a], "R5 no write", rd_data, ref_mem[a]);
      check(rd_data == ref_mem[a], "R6 same edge", rd_data, ref_mem[a]);
      check(burst_addr == exp_burst, wr ? "R7 load" : "R8 step",
            DW'(burst_addr), DW'(exp_burst));
    end

    // final readback: untouched lanes intact (R4)
    @(negedge clk);
    ctl_strobe_n = 1; en_a_n = 1; step_n = 1;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      check(rd_data == ref_mem[a], "R4 readback", rd_data, ref_mem[a]);
    end
    finish_run();
  end
endmodule